// File: doc/BRIEF.md
# Two-Beat Double-Data-Rate SRAM Port

This block is a small, synthesizable static memory behind one shared port that moves data on both halves of the clock. A command is accepted on a rising edge when the active-low load strobe is low; the direction bit and the address are captured with it. Every command moves exactly two data words, one per clock half. Writes carry an active-low select per lane, sampled with each beat, so that individual lanes of each word can be left untouched.

The second word of a burst lives at the partner address of an aligned pair. A build parameter picks one of two addressing modes. In seeded mode the lowest external address bit chooses which word of the pair comes first. In zero-forced mode the internal address gains a zero LSB, so the burst always starts on the even word.

Read data comes back a fixed number of cycles after the command. The port's output enable marks the cycle that carries it. A read issued in the cycle straight after a write sees the lane-merged result of that write.

Top module: `ddr_b2_sram`

## Requirements
- R1: While reset is high and after it is released with no read pending, `rd_oe` is 0 and `rd_data` is all zeros.
- R2: A command starts only when `cmd_load_n` is 0 at a rising edge. `cmd_read` = 1 selects a read and `cmd_read` = 0 selects a write. When `cmd_load_n` is 1, `cmd_read` and `cmd_addr` have no effect.
- R3: For a write loaded at rising edge N, the first beat's data and selects are sampled at rising edge N+1 and the second beat's at the falling edge that follows.
- R4: Selects are active low, one per lane. Lane i covers bits [LANE_W*i +: LANE_W]; with defaults, lane 0 is bits 8:0 and lane 3 is bits 35:27. A lane whose select is 1 keeps its stored value, and each beat uses its own selects.
- R5: With SEED_LSB = 1, beat 0 uses internal word `cmd_addr` and beat 1 uses `cmd_addr` with bit 0 inverted.
- R6: With SEED_LSB = 0, beat 0 uses internal word 2*`cmd_addr` and beat 1 uses word 2*`cmd_addr`+1.
- R7: A read loaded at rising edge N presents beat 0 while the clock is high in the cycle after rising edge N+RD_LAT. It presents beat 1 while the clock is low in that same cycle.
- R8: `rd_oe` is 1 exactly in the cycles that carry read beats, and `rd_data` is all zeros whenever `rd_oe` is 0.
- R9: A read loaded in the cycle right after a write returns the merged data of that write for every word the two bursts share.
- R10: Data and selects presented in a cycle with no write beat due change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges move data |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load_n | input | 1 | Active-low command strobe, sampled on rising edges |
| cmd_read | input | 1 | 1 = read, 0 = write; used only with a command |
| cmd_addr | input | EXT_AW | Burst address, used only with a command |
| wr_data | input | LANE_W*LANES | Write beat data, sampled on both edges |
| wr_lane_n | input | LANES | Active-low per-lane write selects, sampled with the data |
| rd_data | output | LANE_W*LANES | Read beat data, all zeros when idle |
| rd_oe | output | 1 | High while read beats are driven |

## Verification
On every cycle, the assertions check the command decode, including the rule that a deselected strobe starts nothing. They also check that each accepted write produces a commit one cycle later, that each read fetch enters the output pipeline, and that the two words of a committed burst are distinct. The lane merge, the partner-word mapping in both addressing modes, and read-after-write forwarding are shown only by the bench. It runs one instance per addressing mode against a behavioural memory model and compares both beats and the enable on every cycle. Garbage data presented outside write beats is caught only through later readback.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    localparam int unsigned DEF_LANE_W = 9;
    localparam int unsigned DEF_LANES  = 4;
    localparam int unsigned DEF_EXT_AW = 4;
    localparam int unsigned DEF_RD_LAT = 1;

    // internal word address width for a given external width and LSB mode
    function automatic int unsigned word_aw(input int unsigned ext_aw, input bit seeded);
        return seeded ? ext_aw : ext_aw + 1;
    endfunction

endpackage

// File: rtl/ddrb_cmd.sv
module ddrb_cmd
    import ddrb_pkg::*;
#(
    parameter int unsigned EXT_AW   = DEF_EXT_AW,
    parameter bit          SEED_LSB = 1'b1,
    localparam int unsigned IAW     = word_aw(EXT_AW, SEED_LSB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_load_n,
    input  logic              cmd_read,
    input  logic [EXT_AW-1:0] cmd_addr,
    output logic              wr_go,
    output logic              rd_go,
    output logic [IAW-1:0]    beat0_addr,
    output logic [IAW-1:0]    beat1_addr
);

    typedef struct packed {
        logic              valid;
        dir_e              dir;
        logic [EXT_AW-1:0] addr;
    } cmd_t;

    cmd_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held.valid <= 1'b0;
            held.dir   <= DIR_WRITE;
            held.addr  <= '0;
        end else begin
            held.valid <= ~cmd_load_n;
            if (!cmd_load_n) begin
                held.dir  <= dir_e'(cmd_read);
                held.addr <= cmd_addr;
            end
        end
    end

    assign wr_go = held.valid && (held.dir == DIR_WRITE);
    assign rd_go = held.valid && (held.dir == DIR_READ);

    generate
        if (SEED_LSB) begin : g_seeded
            assign beat0_addr = held.addr;
            assign beat1_addr = {held.addr[EXT_AW-1:1], ~held.addr[0]};
        end else begin : g_forced
            assign beat0_addr = {held.addr, 1'b0};
            assign beat1_addr = {held.addr, 1'b1};
        end
    endgenerate

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd_load_n |=> (!wr_go && !rd_go)); // R2
    AST_READ_DECODE: assert property (@(posedge clk) disable iff (rst)
        (!cmd_load_n && cmd_read) |=> (rd_go && !wr_go)); // R2
    AST_WRITE_DECODE: assert property (@(posedge clk) disable iff (rst)
        (!cmd_load_n && !cmd_read) |=> (wr_go && !rd_go)); // R2

endmodule

// File: rtl/ddrb_wbeat.sv
module ddrb_wbeat #(
    parameter int unsigned DW    = 36,
    parameter int unsigned LANES = 4,
    parameter int unsigned IAW   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_go,
    input  logic [IAW-1:0]   beat0_addr,
    input  logic [IAW-1:0]   beat1_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [LANES-1:0] wr_lane_n,
    output logic             commit,
    output logic [IAW-1:0]   c_addr0,
    output logic [IAW-1:0]   c_addr1,
    output logic [DW-1:0]    w0_data,
    output logic [LANES-1:0] w0_lane_n,
    output logic [DW-1:0]    w1_data,
    output logic [LANES-1:0] w1_lane_n
);

    // first beat and burst addresses on the rising edge after the command
    always_ff @(posedge clk) begin
        if (rst) commit <= 1'b0;
        else     commit <= wr_go;
        if (wr_go) begin
            c_addr0   <= beat0_addr;
            c_addr1   <= beat1_addr;
            w0_data   <= wr_data;
            w0_lane_n <= wr_lane_n;
        end
    end

    // second beat on the falling edge inside the commit cycle
    always_ff @(negedge clk) begin
        if (commit) begin
            w1_data   <= wr_data;
            w1_lane_n <= wr_lane_n;
        end
    end

    AST_COMMIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> commit); // R3
    AST_NO_STRAY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !wr_go |=> !commit); // R10

endmodule

// File: rtl/ddrb_array.sv
module ddrb_array #(
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 4,
    parameter int unsigned IAW    = 4,
    localparam int unsigned DW    = LANE_W * LANES,
    localparam int unsigned DEPTH = 1 << IAW
) (
    input  logic             clk,
    input  logic             commit,
    input  logic [IAW-1:0]   c_addr0,
    input  logic [IAW-1:0]   c_addr1,
    input  logic [DW-1:0]    w0_data,
    input  logic [LANES-1:0] w0_lane_n,
    input  logic [DW-1:0]    w1_data,
    input  logic [LANES-1:0] w1_lane_n,
    input  logic [IAW-1:0]   rd_addr0,
    input  logic [IAW-1:0]   rd_addr1,
    output logic [DW-1:0]    fetch0,
    output logic [DW-1:0]    fetch1
);

    logic [DW-1:0] mem [DEPTH];

    function automatic logic [DW-1:0] lane_merge(
        input logic [DW-1:0]    old_w,
        input logic [DW-1:0]    new_w,
        input logic [LANES-1:0] keep_n
    );
        logic [DW-1:0] r;
        r = old_w;
        for (int l = 0; l < LANES; l++) begin
            if (!keep_n[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (commit) begin
            mem[c_addr0] <= lane_merge(mem[c_addr0], w0_data, w0_lane_n);
            mem[c_addr1] <= lane_merge(mem[c_addr1], w1_data, w1_lane_n);
        end
    end

    // forward the burst being committed on this edge into the fetch
    always_comb begin
        fetch0 = mem[rd_addr0];
        if (commit && rd_addr0 == c_addr0) fetch0 = lane_merge(fetch0, w0_data, w0_lane_n);
        if (commit && rd_addr0 == c_addr1) fetch0 = lane_merge(fetch0, w1_data, w1_lane_n);
        fetch1 = mem[rd_addr1];
        if (commit && rd_addr1 == c_addr0) fetch1 = lane_merge(fetch1, w0_data, w0_lane_n);
        if (commit && rd_addr1 == c_addr1) fetch1 = lane_merge(fetch1, w1_data, w1_lane_n);
    end

    always_comb begin
        if (commit) begin
            AST_PAIR_DISTINCT: assert (c_addr0 != c_addr1) else $error("burst words alias"); // R5
        end
    end

endmodule

// File: rtl/ddrb_rdout.sv
module ddrb_rdout #(
    parameter int unsigned DW     = 36,
    parameter int unsigned RD_LAT = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_go,
    input  logic [DW-1:0] fetch0,
    input  logic [DW-1:0] fetch1,
    output logic [DW-1:0] rd_data,
    output logic          rd_oe
);

    localparam int unsigned NST = (RD_LAT < 1) ? 1 : RD_LAT;

    logic          pv  [NST];
    logic [DW-1:0] pd0 [NST];
    logic [DW-1:0] pd1 [NST];

    generate
        for (genvar i = 0; i < NST; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) pv[0] <= 1'b0;
                    else     pv[0] <= rd_go;
                    if (rd_go) begin
                        pd0[0] <= fetch0;
                        pd1[0] <= fetch1;
                    end
                end
                AST_FETCH_ENTERS: assert property (@(posedge clk) disable iff (rst)
                    rd_go |=> pv[0]); // R7
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) pv[i] <= 1'b0;
                    else     pv[i] <= pv[i-1];
                    pd0[i] <= pd0[i-1];
                    pd1[i] <= pd1[i-1];
                end
                AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
                    pv[i-1] |=> pv[i]); // R7
            end
        end
    endgenerate

    // beat 0 while the clock is high, beat 1 while it is low
    assign rd_oe   = pv[NST-1];
    assign rd_data = !rd_oe ? '0 : (clk ? pd0[NST-1] : pd1[NST-1]);

endmodule

// File: rtl/ddr_b2_sram.sv
module ddr_b2_sram
    import ddrb_pkg::*;
#(
    parameter int unsigned LANE_W   = DEF_LANE_W,
    parameter int unsigned LANES    = DEF_LANES,
    parameter int unsigned EXT_AW   = DEF_EXT_AW,
    parameter int unsigned RD_LAT   = DEF_RD_LAT,
    parameter bit          SEED_LSB = 1'b1,
    localparam int unsigned DW      = LANE_W * LANES,
    localparam int unsigned IAW     = word_aw(EXT_AW, SEED_LSB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_load_n,
    input  logic              cmd_read,
    input  logic [EXT_AW-1:0] cmd_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [LANES-1:0]  wr_lane_n,
    output logic [DW-1:0]     rd_data,
    output logic              rd_oe
);

    logic             wr_go, rd_go, commit;
    logic [IAW-1:0]   b0_addr, b1_addr, c_addr0, c_addr1;
    logic [DW-1:0]    w0_data, w1_data, fetch0, fetch1;
    logic [LANES-1:0] w0_lane_n, w1_lane_n;

    ddrb_cmd #(.EXT_AW(EXT_AW), .SEED_LSB(SEED_LSB)) u_cmd (
        .clk(clk), .rst(rst), .cmd_load_n(cmd_load_n), .cmd_read(cmd_read),
        .cmd_addr(cmd_addr), .wr_go(wr_go), .rd_go(rd_go),
        .beat0_addr(b0_addr), .beat1_addr(b1_addr)
    );

    ddrb_wbeat #(.DW(DW), .LANES(LANES), .IAW(IAW)) u_wbeat (
        .clk(clk), .rst(rst), .wr_go(wr_go), .beat0_addr(b0_addr),
        .beat1_addr(b1_addr), .wr_data(wr_data), .wr_lane_n(wr_lane_n),
        .commit(commit), .c_addr0(c_addr0), .c_addr1(c_addr1),
        .w0_data(w0_data), .w0_lane_n(w0_lane_n),
        .w1_data(w1_data), .w1_lane_n(w1_lane_n)
    );

    ddrb_array #(.LANE_W(LANE_W), .LANES(LANES), .IAW(IAW)) u_array (
        .clk(clk), .commit(commit), .c_addr0(c_addr0), .c_addr1(c_addr1),
        .w0_data(w0_data), .w0_lane_n(w0_lane_n),
        .w1_data(w1_data), .w1_lane_n(w1_lane_n),
        .rd_addr0(b0_addr), .rd_addr1(b1_addr),
        .fetch0(fetch0), .fetch1(fetch1)
    );

    ddrb_rdout #(.DW(DW), .RD_LAT(RD_LAT)) u_rdout (
        .clk(clk), .rst(rst), .rd_go(rd_go), .fetch0(fetch0), .fetch1(fetch1),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

endmodule

// File: tb/tb_ddr_b2_sram.sv
module tb_ddr_b2_sram;
    localparam int LW = 9, NL = 4, DW = LW * NL, EAW = 4, RDL = 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, ld_n, rd_bit;
    logic [EAW-1:0] addr;
    logic [DW-1:0] wdata, rd_s, rd_z;
    logic [NL-1:0] wsel_n;
    logic oe_s, oe_z;

    ddr_b2_sram #(.SEED_LSB(1'b1)) dut (
        .clk(clk), .rst(rst), .cmd_load_n(ld_n), .cmd_read(rd_bit), .cmd_addr(addr),
        .wr_data(wdata), .wr_lane_n(wsel_n), .rd_data(rd_s), .rd_oe(oe_s));
    ddr_b2_sram #(.SEED_LSB(1'b0)) dut_z (
        .clk(clk), .rst(rst), .cmd_load_n(ld_n), .cmd_read(rd_bit), .cmd_addr(addr),
        .wr_data(wdata), .wr_lane_n(wsel_n), .rd_data(rd_z), .rd_oe(oe_z));

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    logic [DW-1:0] ms [16];
    logic [DW-1:0] mz [32];

    typedef struct {
        int due; logic [DW-1:0] s0, s1, z0, z1; string tag;
    } exp_t;
    exp_t q[$];

    bit sn_v = 0; logic [EAW-1:0] sn_a; int sn_due; string sn_tag;
    bit hv = 0; logic [EAW-1:0] ha; logic [DW-1:0] hd0, hd1; logic [NL-1:0] hs0, hs1;

    function automatic logic [DW-1:0] mrg(logic [DW-1:0] o, logic [DW-1:0] n, logic [NL-1:0] s);
        logic [DW-1:0] r;
        for (int b = 0; b < DW; b++) r[b] = s[b / LW] ? o[b] : n[b];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(int a, int k);
        return (36'h9_A5C3_1E70 ^ (DW'(a) * 36'h1_0101_0101)) + DW'(k * 36'h0_3771);
    endfunction

    task automatic chk(string tg, logic go, logic [DW-1:0] gd, logic eo, logic [DW-1:0] ed);
        checks++;
        if (go !== eo || gd !== ed) begin
            errors++;
            $display("FAIL %s cyc %0d: oe=%0b data=%h expected oe=%0b data=%h", tg, cyc, go, gd, eo, ed);
        end
    endtask

    task automatic check_half(bit fall);
        if (q.size() > 0 && q[0].due == cyc) begin
            chk(q[0].tag, oe_s, rd_s, 1'b1, fall ? q[0].s1 : q[0].s0);
            chk({q[0].tag, " R6"}, oe_z, rd_z, 1'b1, fall ? q[0].z1 : q[0].z0);
            if (fall) void'(q.pop_front());
        end else begin
            chk("R8", oe_s, rd_s, 1'b0, '0);
            chk("R8", oe_z, rd_z, 1'b0, '0);
        end
    endtask

    // one clock cycle; the write data passed here is driven in the next cycle
    task automatic issue(bit ld, bit rd, logic [EAW-1:0] a, logic [DW-1:0] d0, logic [NL-1:0] s0,
                         logic [DW-1:0] d1, logic [NL-1:0] s1, string tg);
        if (sn_v) begin
            exp_t e;
            e.due = sn_due; e.tag = sn_tag;
            e.s0 = ms[sn_a]; e.s1 = ms[sn_a ^ 4'd1];           // R5 mapping
            e.z0 = mz[{sn_a, 1'b0}]; e.z1 = mz[{sn_a, 1'b1}]; // R6 mapping
            q.push_back(e);
            sn_v = 0;
        end
        ld_n = ~ld; rd_bit = rd; addr = a;
        wdata  = hv ? hd0 : (36'hF_0F0F_0F0F ^ DW'(cyc)); // R10 garbage when no beat is due
        wsel_n = hv ? hs0 : '0;
        @(posedge clk);
        cyc++;
        if (ld && rd) begin sn_v = 1; sn_a = a; sn_due = cyc + RDL; sn_tag = tg; end
        #5 check_half(1'b0);
        wdata  = hv ? hd1 : (36'h0_F0F0_F0F0 ^ DW'(cyc));
        wsel_n = hv ? hs1 : '0;
        @(negedge clk);
        if (hv) begin
            ms[ha] = mrg(ms[ha], hd0, hs0);
            ms[ha ^ 4'd1] = mrg(ms[ha ^ 4'd1], hd1, hs1);
            mz[{ha, 1'b0}] = mrg(mz[{ha, 1'b0}], hd0, hs0);
            mz[{ha, 1'b1}] = mrg(mz[{ha, 1'b1}], hd1, hs1);
        end
        hv = ld && !rd; ha = a; hd0 = d0; hs0 = s0; hd1 = d1; hs1 = s1;
        #5 check_half(1'b1);
    endtask

    task automatic wr(logic [EAW-1:0] a, logic [DW-1:0] d0, logic [NL-1:0] s0,
                      logic [DW-1:0] d1, logic [NL-1:0] s1, string tg);
        issue(1, 0, a, d0, s0, d1, s1, tg);
    endtask
    task automatic rdc(logic [EAW-1:0] a, string tg);
        issue(1, 1, a, '0, '0, '0, '0, tg);
    endtask
    task automatic idle(logic [EAW-1:0] junk_a, bit junk_rw);
        issue(0, junk_rw, junk_a, '0, '0, '0, '0, "R8");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        rst = 1; ld_n = 1; rd_bit = 0; addr = '0; wdata = '0; wsel_n = '1;
        repeat (3) @(posedge clk);
        @(negedge clk); #5;
        // R1: reset state of both instances
        chk("R1", oe_s, rd_s, 1'b0, '0);
        chk("R1", oe_z, rd_z, 1'b0, '0);
        rst = 0;
        idle(4'hA, 1);
        chk("R1", oe_s, rd_s, 1'b0, '0);

        // R3: fill every word back-to-back with full-lane writes
        for (int a = 0; a < 16; a++) wr(a[3:0], pat(a, 1), 4'b0000, pat(a, 2), 4'b0000, "R3");
        // R5: read all, even and odd seeds, back-to-back
        for (int a = 0; a < 16; a++) rdc(a[3:0], "R5");
        // R2/R10: deselected cycles with junk address, direction and data
        for (int i = 0; i < 6; i++) idle(4'(i * 5), i[0]);
        for (int a = 0; a < 16; a += 3) rdc(a[3:0], "R10");
        // R7: isolated reads with gaps
        rdc(4'd7, "R7"); idle(4'd7, 0); rdc(4'd2, "R7"); idle(4'd1, 1); idle(4'd0, 0);

        // R4: per-lane, per-beat masks
        wr(4'd4, 36'h1_2345_6789, 4'b1010, 36'hF_EDCB_A987, 4'b0101, "R4");
        wr(4'd9, 36'hA_AAAA_AAAA, 4'b1110, 36'h5_5555_5555, 4'b0111, "R4");
        wr(4'd12, 36'h0_0000_0000, 4'b1111, 36'hF_FFFF_FFFF, 4'b0110, "R4");
        idle(4'd3, 1);
        rdc(4'd4, "R4"); rdc(4'd9, "R4"); rdc(4'd12, "R4"); rdc(4'd13, "R4"); rdc(4'd8, "R4");

        // R9: read loaded right after a write sharing words
        wr(4'd6, 36'h3_1415_9265, 4'b0011, 36'h2_7182_8182, 4'b1001, "R9");
        rdc(4'd6, "R9");
        wr(4'd10, 36'hC_0FFE_E123, 4'b0000, 36'hB_EEF0_0456, 4'b1100, "R9");
        rdc(4'd11, "R9");
        wr(4'd1, 36'h7_7777_0000, 4'b0100, 36'h8_8888_1111, 4'b0000, "R9");
        rdc(4'd0, "R9");
        // R2: alternating directions
        wr(4'd14, pat(14, 9), 4'b0000, pat(15, 9), 4'b0001, "R2");
        rdc(4'd15, "R2");
        wr(4'd3, pat(3, 7), 4'b1000, pat(3, 8), 4'b0000, "R2");
        wr(4'd5, pat(5, 7), 4'b0000, pat(5, 8), 4'b1111, "R2");
        rdc(4'd3, "R2"); rdc(4'd5, "R2"); rdc(4'd14, "R2");
        for (int i = 0; i < 4; i++) idle(4'hF, 1);

        // R10: final sweep of the whole array after all junk cycles
        for (int a = 0; a < 16; a++) rdc(a[3:0], "R10");
        for (int i = 0; i < 4; i++) idle(4'h6, 0);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R7 cyc %0d: %0d expected reads never returned, expected 0", cyc, q.size());
        end
        summary();
    end
endmodule